// File: doc/BRIEF.md
# AGP Aperture Address Translator

This block turns addresses that fall inside a graphics aperture into system physical addresses. The mapping comes from a page table that sits in system memory, with one 32-bit entry per 4 KB page. Each entry is stored little-endian, so the block byte-swaps every fetched word before it reads the valid flag in bit 0 and the physical page number in bits 31:12. An eight-entry fully associative translation cache keeps recent mappings, so a repeated page needs no memory read.

Software sets the block up through a small register port that holds four registers. The aperture-base register keeps only its top four bits, which gives 256 MB granularity. The table-base register holds the page-aligned table address in its upper bits and the table length, counted in 4 KB table pages, in its low 12 bits. The control register turns translation on and off and empties the cache. The status register reports whether the engine is busy. Translation requests come in on a request port, and one response leaves for each request. On a cache miss the block issues a single read on a simple memory port and waits for the data before it responds.

Top module: `apt_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` and `mem_req` are 0, and the control and status registers read 0. The cache is empty.
- R2: A write to register select 0 (aperture base) keeps only bits 31:28. Reading it back returns those bits with bits 27:0 at zero. The register at select 1 reads back exactly as written.
- R3: A write to control (select 2) sets the enable from bit 8, but a 1 in bit 17 forces it off. Control reads back the enable in bit 8. A request made while translation is off returns an error response (`resp_err`=1, `resp_addr`=0) and issues no memory read.
- R4: A request whose bits 31:28 differ from the aperture base returns an error response and issues no memory read.
- R5: The page index is bits 27:12 of the request. An index at or beyond 1024 × (table-base bits 11:0) returns an error response and issues no memory read.
- R6: A cache miss issues exactly one memory read, one cycle wide, at ({table-base bits 31:12}, 12'b0) + 4 × index, two cycles after the request is accepted. The response comes one cycle after the cycle in which `mem_rvalid` is high.
- R7: The fetched word is byte-swapped. If bit 0 of the swapped word is 1, the response is swapped bits 31:12 joined with request bits 11:0. If bit 0 is 0, the response is an error, and the entry is not cached.
- R8: A request that hits the cache responds two cycles after it is accepted, issues no memory read, and returns the cached physical page joined with request bits 11:0.
- R9: The cache holds 8 valid entries, each for a distinct page. Fills replace entries in round-robin order, starting from entry 0 after reset or a flush.
- R10: A control write with bit 0 or bit 16 set empties the cache and resets the replacement order. So do the four-write flush sequence (0x101, 0x100, 0x10100, 0x100) and the shutdown sequence (0x101, then 0x10000). The shutdown sequence leaves translation off.
- R11: Status (select 3) bit 0 reads 1 from the cycle after a request is accepted until the response cycle, and reads 0 otherwise.
- R12: A flush while a memory read is outstanding still delivers the response from the returned data, but that mapping is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 aperture, 1 table base, 2 control, 3 status |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_sel` (combinational) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Aperture address to translate |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_err | output | 1 | Response is an error |
| resp_addr | output | 32 | Translated physical address (0 on error) |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 32 | Table entry as stored in memory |

## Verification
Take the edge at which a request is accepted as edge 0. Error and hit responses register at edge 1 and are visible after it. A miss raises `mem_req` after edge 1, and its response follows the edge that samples `mem_rvalid`. So with L idle cycles of memory latency, the response arrives three plus L cycles after acceptance. The bench drives and samples on falling edges and counts falling edges from acceptance. It compares each response's arrival count exactly against 2 or 3+L, and it checks busy status on the first falling edge and idle status on the response edge. A reference cache model in the bench predicts hits, fills and round-robin evictions, and so predicts which requests must fetch. The bench computes table entries from the index.

// File: rtl/apt_pkg.sv
package apt_pkg;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOOK,
      ST_WAIT
   } apt_state_e;

   localparam logic [1:0] SEL_APER = 2'd0;
   localparam logic [1:0] SEL_TBL  = 2'd1;
   localparam logic [1:0] SEL_CTRL = 2'd2;
   localparam logic [1:0] SEL_STAT = 2'd3;

   localparam int CTL_INV = 0;
   localparam int CTL_EN  = 8;
   localparam int CTL_RST = 16;
   localparam int CTL_OFF = 17;

   function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction
endpackage

// File: rtl/apt_cfg.sv
module apt_cfg
   import apt_pkg::*;
#(
   parameter int APER_BITS = 4,
   parameter int SIZE_W    = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [1:0]               sel,
   input  logic [WORD_W-1:0]        wdata,
   input  logic                     busy,
   output logic [WORD_W-1:0]        rdata,
   output logic [APER_BITS-1:0]     aper_tag,
   output logic [WORD_W-SIZE_W-1:0] tbl_page,
   output logic [SIZE_W-1:0]        tbl_pages,
   output logic                     enable,
   output logic                     flush
);
   localparam int LOW_W = WORD_W - APER_BITS;

   logic [APER_BITS-1:0] aper_q;
   logic [WORD_W-1:0]    tbl_q;
   logic                 en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aper_q <= '0;
         tbl_q  <= '0;
         en_q   <= 1'b0;
      end else if (we) begin
         case (sel)
            SEL_APER: aper_q <= wdata[WORD_W-1 -: APER_BITS];
            SEL_TBL:  tbl_q  <= wdata;
            SEL_CTRL: en_q   <= wdata[CTL_EN] & ~wdata[CTL_OFF];
            default: ;
         endcase
      end
   end

   assign flush     = we && (sel == SEL_CTRL) && (wdata[CTL_INV] || wdata[CTL_RST]);
   assign aper_tag  = aper_q;
   assign tbl_page  = tbl_q[WORD_W-1:SIZE_W];
   assign tbl_pages = tbl_q[SIZE_W-1:0];
   assign enable    = en_q;

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_APER: rdata = {aper_q, {LOW_W{1'b0}}};
         SEL_TBL:  rdata = tbl_q;
         SEL_CTRL: rdata[CTL_EN] = en_q;
         default:  rdata[0] = busy;
      endcase
   end
endmodule

// File: rtl/apt_tlb.sv
module apt_tlb #(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 20,
   parameter int DATA_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [TAG_W-1:0]  look_tag,
   output logic              hit,
   output logic [DATA_W-1:0] hit_data,
   input  logic              fill,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("apt_tlb: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0]  vld_q;
   logic [TAG_W-1:0]  tag_q [DEPTH];
   logic [DATA_W-1:0] dat_q [DEPTH];
   logic [PTR_W-1:0]  ptr_q;
   logic [DEPTH-1:0]  match;

   for (genvar g = 0; g < DEPTH; g++) begin : g_way
      assign match[g] = vld_q[g] && (tag_q[g] == look_tag);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
            tag_q[g] <= '0;
            dat_q[g] <= '0;
         end else if (flush) begin
            vld_q[g] <= 1'b0;
         end else if (fill && ptr_q == PTR_W'(g)) begin
            vld_q[g] <= 1'b1;
            tag_q[g] <= fill_tag;
            dat_q[g] <= fill_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) ptr_q <= '0;
      else if (fill)       ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   end

   always_comb begin
      hit_data = '0;
      for (int i = 0; i < DEPTH; i++)
         if (match[i]) hit_data = hit_data | dat_q[i];
   end
   assign hit = |match;

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0)) else $error("flush left entries"); // R10
   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)) else $error("duplicate cache match"); // R9
endmodule

// File: rtl/apt_xlate.sv
module apt_xlate
   import apt_pkg::*;
#(
   parameter int PAGE_SHIFT = 12,
   parameter int APER_BITS  = 4,
   parameter int TLB_DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [WORD_W-1:0] cfg_wdata,
   output logic [WORD_W-1:0] cfg_rdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [WORD_W-1:0] req_addr,
   output logic              resp_valid,
   output logic              resp_err,
   output logic [WORD_W-1:0] resp_addr,
   output logic              mem_req,
   output logic [WORD_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [WORD_W-1:0] mem_rdata
);
   localparam int VPN_W  = WORD_W - PAGE_SHIFT;
   localparam int IDX_HI = WORD_W - APER_BITS - 1;
   localparam int SIZE_W = PAGE_SHIFT;
   localparam int EPP_SH = PAGE_SHIFT - 2;
   localparam int CMP_W  = WORD_W + 1;

   if (PAGE_SHIFT < 3 || APER_BITS < 1 || IDX_HI < PAGE_SHIFT) begin : g_bad_geom
      $error("apt_xlate: invalid page or aperture geometry");
   end

   apt_state_e state_q;
   logic [WORD_W-1:0] req_q;
   logic stale_q;

   logic [APER_BITS-1:0] aper_tag;
   logic [VPN_W-1:0]     tbl_page;
   logic [SIZE_W-1:0]    tbl_pages;
   logic                 enable, flush, busy;

   logic              hit, fill;
   logic [VPN_W-1:0]  hit_data;
   logic [WORD_W-1:0] ent_sw;
   logic [CMP_W-1:0]  idx_ext, lim_ext;
   logic [WORD_W-1:0] fetch_addr;
   logic              in_aper, over, err_pre;

   assign busy      = (state_q != ST_IDLE);
   assign req_ready = (state_q == ST_IDLE);

   apt_cfg #(.APER_BITS(APER_BITS), .SIZE_W(SIZE_W)) i_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .busy(busy), .rdata(cfg_rdata), .aper_tag(aper_tag), .tbl_page(tbl_page),
      .tbl_pages(tbl_pages), .enable(enable), .flush(flush)
   );

   assign in_aper    = (req_q[WORD_W-1 -: APER_BITS] == aper_tag);
   assign idx_ext    = CMP_W'(req_q[IDX_HI:PAGE_SHIFT]);
   assign lim_ext    = CMP_W'(tbl_pages) << EPP_SH;
   assign over       = (idx_ext >= lim_ext);
   assign err_pre    = !enable || !in_aper || over;
   assign fetch_addr = {tbl_page, {SIZE_W{1'b0}}} + (WORD_W'(req_q[IDX_HI:PAGE_SHIFT]) << 2);
   assign ent_sw     = swap_bytes(mem_rdata);
   assign fill       = (state_q == ST_WAIT) && mem_rvalid && ent_sw[0] && !stale_q;

   apt_tlb #(.DEPTH(TLB_DEPTH), .TAG_W(VPN_W), .DATA_W(VPN_W)) i_tlb (
      .clk(clk), .rst_n(rst_n), .flush(flush), .look_tag(req_q[WORD_W-1:PAGE_SHIFT]),
      .hit(hit), .hit_data(hit_data), .fill(fill),
      .fill_tag(req_q[WORD_W-1:PAGE_SHIFT]), .fill_data(ent_sw[WORD_W-1:PAGE_SHIFT])
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         req_q      <= '0;
         stale_q    <= 1'b0;
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_addr  <= '0;
         mem_req    <= 1'b0;
         mem_addr   <= '0;
      end else begin
         resp_valid <= 1'b0;
         mem_req    <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  req_q   <= req_addr;
                  state_q <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               stale_q <= 1'b0;
               if (err_pre) begin
                  resp_valid <= 1'b1;
                  resp_err   <= 1'b1;
                  resp_addr  <= '0;
                  state_q    <= ST_IDLE;
               end else if (hit) begin
                  resp_valid <= 1'b1;
                  resp_err   <= 1'b0;
                  resp_addr  <= {hit_data, req_q[PAGE_SHIFT-1:0]};
                  state_q    <= ST_IDLE;
               end else begin
                  mem_req  <= 1'b1;
                  mem_addr <= fetch_addr;
                  state_q  <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (flush) stale_q <= 1'b1;
               if (mem_rvalid) begin
                  resp_valid <= 1'b1;
                  resp_err   <= !ent_sw[0];
                  resp_addr  <= ent_sw[0] ? {ent_sw[WORD_W-1:PAGE_SHIFT], req_q[PAGE_SHIFT-1:0]} : '0;
                  state_q    <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req) else $error("fetch wider than one cycle"); // R6
   AST_FETCH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> $past(enable)) else $error("fetch while disabled"); // R3
   AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid) else $error("response held"); // R8
   AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (cfg_sel != SEL_STAT || cfg_rdata[0])) else $error("idle during fetch"); // R11
endmodule

// File: tb/test_apt_xlate.sv
module test_apt_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd3;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        resp_valid, resp_err;
   logic [31:0] resp_addr;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // bench model of configuration and cache
   logic [3:0]  m_aper = '0;
   logic [31:0] m_tbl = '0;
   bit          m_en = 1'b0;
   logic [19:0] m_tag [8];
   bit          m_v [8];
   int          m_ptr = 0;

   always #4 clk = ~clk;

   apt_xlate i_apt_xlate (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .resp_valid(resp_valid), .resp_err(resp_err), .resp_addr(resp_addr), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ent_of(input int i);
      logic [19:0] ppn;
      ppn = 20'h80000 + 20'(i * 3);
      return {ppn, 11'(i * 5 + 1), (i % 7) != 5};
   endfunction

   function automatic logic [31:0] swap(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   function automatic void m_flush();
      for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
      m_ptr = 0;
   endfunction

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_sel = 2'd3;
      case (sel)
         2'd0: m_aper = d[31:28];
         2'd1: m_tbl = d;
         2'd2: begin
            m_en = d[8] && !d[17];
            if (d[0] || d[16]) m_flush();
         end
         default: ;
      endcase
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] v);
      @(negedge clk);
      cfg_sel = sel;
      #1 v = cfg_rdata;
      cfg_sel = 2'd3;
   endtask

   task automatic xlate(input logic [31:0] a, input int lat, input bit flush_mid, input string req);
      int idx, lim, rk, due, nf, hitw;
      bit exp_err, exp_fetch, got_err;
      logic [31:0] exp_pa, got_pa, fa, exp_fa, raw;
      idx = int'(a[27:12]);
      lim = int'(m_tbl[11:0]) * 1024;
      hitw = -1;
      for (int i = 0; i < 8; i++) if (m_v[i] && m_tag[i] == a[31:12]) hitw = i;
      exp_fetch = 1'b0; exp_err = 1'b0; exp_pa = '0;
      exp_fa = {m_tbl[31:12], 12'h000} + 32'(idx * 4);
      if (!m_en || a[31:28] != m_aper || idx >= lim) exp_err = 1'b1;
      else if (hitw >= 0) exp_pa = {ent_of(idx)[31:12], a[11:0]};
      else begin
         exp_fetch = 1'b1;
         if (ent_of(idx)[0]) exp_pa = {ent_of(idx)[31:12], a[11:0]};
         else exp_err = 1'b1;
      end
      @(negedge clk);
      check(req_ready === 1'b1, "R11 ready before request", 32'(req_ready), 32'h1);
      req_valid = 1'b1; req_addr = a;
      rk = -1; due = -1; nf = 0; fa = '0; got_err = 1'b0; got_pa = '0;
      for (int k = 1; k < 40; k++) begin
         @(negedge clk);
         mem_rvalid = 1'b0;
         if (cfg_we) begin cfg_we = 1'b0; cfg_sel = 2'd3; end
         if (k == 1) begin
            req_valid = 1'b0;
            #1 check(cfg_rdata[0] === 1'b1, "R11 busy after accept", cfg_rdata, 32'h1);
         end
         if (mem_req) begin
            nf++; fa = mem_addr; due = k + lat;
            check(k == 2, "R6 fetch timing", 32'(k), 32'd2);
            if (flush_mid) begin
               cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h101;
               m_flush();
            end
         end
         if (due == k) begin
            raw = swap(ent_of(int'((fa - {m_tbl[31:12], 12'h000}) >> 2)));
            mem_rvalid = 1'b1; mem_rdata = raw;
         end
         if (resp_valid) begin
            rk = k; got_err = resp_err; got_pa = resp_addr;
            #1 check(cfg_rdata[0] === 1'b0, "R11 idle at response", cfg_rdata, 32'h0);
            break;
         end
      end
      mem_rvalid = 1'b0;
      check(nf == (exp_fetch ? 1 : 0), {req, " fetch count"}, 32'(nf), 32'(exp_fetch));
      if (exp_fetch) check(fa == exp_fa, "R6 fetch address", fa, exp_fa);
      check(rk == (exp_fetch ? 3 + lat : 2), {req, " response cycle"}, 32'(rk), exp_fetch ? 32'(3 + lat) : 32'd2);
      check(got_err == exp_err, {req, " error flag"}, 32'(got_err), 32'(exp_err));
      check(got_pa == exp_pa, {req, " physical address"}, got_pa, exp_pa);
      if (exp_fetch && !exp_err && !flush_mid) begin
         m_tag[m_ptr] = a[31:12]; m_v[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 8;
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      m_flush();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready === 1'b1 && resp_valid === 1'b0 && mem_req === 1'b0, "R1 reset outputs",
            {29'd0, req_ready, resp_valid, mem_req}, 32'h4);
      rd(2'd3, v); check(v == 32'h0, "R1 status idle", v, 32'h0);
      rd(2'd2, v); check(v == 32'h0, "R1 control off", v, 32'h0);
      // R3 disabled
      xlate(32'h0000_1234, 0, 1'b0, "R3 disabled");
      // R2 register readback
      wr(2'd0, 32'h4ABC_DEF0); rd(2'd0, v); check(v == 32'h4000_0000, "R2 aperture mask", v, 32'h4000_0000);
      wr(2'd1, 32'h0010_0001); rd(2'd1, v); check(v == 32'h0010_0001, "R2 table base", v, 32'h0010_0001);
      wr(2'd2, 32'h0000_0100); rd(2'd2, v); check(v == 32'h100, "R3 enable readback", v, 32'h100);
      // R4 aperture bounds
      xlate(32'h5000_0000, 0, 1'b0, "R4 above aperture");
      xlate(32'h3FFF_FFFF, 0, 1'b0, "R4 below aperture");
      // R5 table limit
      xlate(32'h4040_0000, 0, 1'b0, "R5 index at limit");
      xlate(32'h403F_F123, 1, 1'b0, "R5 last index");
      // R6 R7 R8 R9 sweep with round-robin evictions
      for (int i = 0; i < 24; i++)
         xlate(32'h4000_0000 | 32'(i << 12) | 32'((i * 32'h1F3) & 32'hFFF), i % 3, 1'b0, "R7 sweep");
      for (int i = 0; i < 24; i++)
         xlate(32'h4000_0000 | 32'((23 - i) << 12) | 32'(i * 7), 1, 1'b0, "R9 revisit");
      for (int i = 16; i < 24; i++)
         xlate(32'h4000_0000 | 32'(i << 12) | 32'h0AB, 0, 1'b0, "R8 hit");
      // R5 larger table
      wr(2'd1, 32'h0010_0002);
      xlate(32'h4040_0FFF, 2, 1'b0, "R5 two table pages");
      // R10 four-write flush sequence
      xlate(32'h4001_4000, 0, 1'b0, "R8 warm");
      wr(2'd2, 32'h101); wr(2'd2, 32'h100); wr(2'd2, 32'h10100); wr(2'd2, 32'h100);
      xlate(32'h4001_4000, 0, 1'b0, "R10 after flush sequence");
      // R12 flush while fetch outstanding
      xlate(32'h4001_E010, 2, 1'b1, "R12 flush mid fetch");
      xlate(32'h4001_E020, 0, 1'b0, "R12 not cached");
      // R3 disable flag
      wr(2'd2, 32'h20100); rd(2'd2, v); check(v == 32'h0, "R3 bit17 forces off", v, 32'h0);
      xlate(32'h4001_E020, 0, 1'b0, "R3 off by bit17");
      // R10 shutdown then re-enable
      wr(2'd2, 32'h100);
      xlate(32'h4000_1000, 0, 1'b0, "R8 warm again");
      wr(2'd2, 32'h101); wr(2'd2, 32'h10000);
      rd(2'd2, v); check(v == 32'h0, "R10 shutdown disables", v, 32'h0);
      xlate(32'h4000_1000, 0, 1'b0, "R10 after shutdown");
      wr(2'd2, 32'h100);
      xlate(32'h4000_1000, 1, 1'b0, "R10 cache empty after shutdown");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule